// File: doc/BRIEF.md
# DS3 Overhead Defect Integrator

This block receives per-frame overhead observations from a DS3 receive path and filters them into four stable defect flags. The observations are the framer's out-of-frame state, the two X bits, the first C bit of the frame, and the three C bits of each subframe. Each flag has its own persistence rules. Loss of frame and C1-high use counts of consecutive frames in both directions. The remote-alarm flag uses two-frame runs in both directions. The all-C-zero flag is raised after three clean frames and dropped by a single all-ones subframe.

Every change of a flag makes a one-cycle pulse and sets a sticky change bit. Software clears a sticky bit by writing a one to it. A mask register decides which sticky bits reach the combined interrupt.

A frame ends on the cycle where `frameStb` is high. Every `subStb` seen since the previous frame end, including one in that same cycle, belongs to the frame that is ending. The framer, the extraction of overhead bits and the register bus all sit outside this block.

Top module: `ds3_defect_integrator`

## Requirements
- R1: `lofOut` rises on the frame strobe that completes 28 consecutive frames with `oofIn` high. It stays low after 27 such frames.
- R2: Once set, `lofOut` falls on the frame strobe that completes 28 consecutive frames with `oofIn` low. It stays high after 27 such frames.
- R3: `c1HighOut` rises on the frame strobe that completes 8 consecutive frames with `c1In` = 1. Fewer frames leave it low.
- R4: Once set, `c1HighOut` falls on the frame strobe that completes 3 consecutive frames with `c1In` = 0.
- R5: `raiOut` rises after 2 consecutive frames with `xBits` = 2'b00. It falls after 2 consecutive frames with `xBits` = 2'b11. A frame in which the two X bits differ breaks both kinds of run.
- R6: `cZeroOut` rises on the frame strobe that completes 3 consecutive frames in which every subframe carried `subCBits` = 3'b000.
- R7: `cZeroOut` falls in the cycle after any `subStb` with `subCBits` = 3'b111, whether or not a frame strobe is present. Such a subframe also breaks the run of zero frames.
- R8: A frame that breaks a run restarts that run's count from zero. For example, 20 frames with `oofIn` high, then 1 low, then 27 high leaves `lofOut` low.
- R9: `evtPulse` is high for exactly one cycle, in the first cycle a flag shows its new value. The bit order is 0 = loss of frame, 1 = C1-high, 2 = remote alarm, 3 = all-C-zero.
- R10: A change sets a sticky bit in the same bit order. A `clrStb` cycle clears the sticky bits selected by ones in `clrBits`, and a new change wins over a clear in the same cycle. `maskWr` loads `maskData` into the mask. `irqOut` is the OR of the sticky bits whose mask bit is 0.
- R11: After reset, all flags, pulses, sticky bits, the mask, `irqOut` and all run counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStb | input | 1 | End-of-frame strobe; qualifies oofIn, xBits, c1In |
| oofIn | input | 1 | Framer out-of-frame state |
| xBits | input | 2 | The two X bits of the frame |
| c1In | input | 1 | First C bit of the frame |
| subStb | input | 1 | Subframe strobe; qualifies subCBits |
| subCBits | input | 3 | The three C bits of one subframe |
| maskWr | input | 1 | Load strobe for the mask |
| maskData | input | 4 | New mask value, 1 = suppress |
| clrStb | input | 1 | Write-one-to-clear strobe for the sticky bits |
| clrBits | input | 4 | Sticky bits to clear |
| lofOut | output | 1 | Loss-of-frame flag |
| c1HighOut | output | 1 | C1-high flag |
| raiOut | output | 1 | Remote-alarm flag |
| cZeroOut | output | 1 | All-C-zero flag |
| evtPulse | output | 4 | One-cycle change pulses |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench sweeps run lengths on both sides of every threshold: 26 to 29 frames for loss of frame, and 1 to 9 for C1. It sweeps the clear runs the same way. A design with an off-by-one count would flip a flag one frame early or late. Interrupted runs check that counts restart from zero; a design that only holds its count would declare too soon. Mixed X bits check that both remote-alarm runs break. An all-ones subframe is sent with no frame strobe, so a design that waits for frame end to clear all-C-zero would hold the flag for one frame too long. The interrupt path is tested with a masked event, an unmask, a clear of an unrelated bit, and a real clear. A design with inverted masking or a clear that hits every bit would show the wrong `irqOut`.

// File: rtl/ds3d_pkg.sv
package ds3d_pkg;

  localparam int NUM_DEF = 4;
  localparam int IDX_LOF = 0;
  localparam int IDX_C1  = 1;
  localparam int IDX_RAI = 2;
  localparam int IDX_CZ  = 3;

  typedef logic [NUM_DEF-1:0] defVec_t;

  // strobes from the control module to the datapath
  typedef struct packed {
    logic    frameTick;
    defVec_t setCond;
    defVec_t clrCond;
    defVec_t instClr;
    logic    maskLoad;
    defVec_t maskVal;
    defVec_t ackBits;
  } ctrlStrobes_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ds3d_ctrl.sv
module ds3d_ctrl
  import ds3d_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameStb,
  input  logic         oofIn,
  input  logic [1:0]   xBits,
  input  logic         c1In,
  input  logic         subStb,
  input  logic [2:0]   subCBits,
  input  logic         maskWr,
  input  logic [NUM_DEF-1:0] maskData,
  input  logic         clrStb,
  input  logic [NUM_DEF-1:0] clrBits,
  output ctrlStrobes_t strobes
);

  logic seenOneQ;
  logic subHasOne;
  logic subAllOne;
  logic frameZero;

  assign subHasOne = subStb & (|subCBits);
  assign subAllOne = subStb & (&subCBits);
  assign frameZero = ~(seenOneQ | subHasOne);

  // tracks whether any C bit of the current frame was 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenOneQ <= 1'b0;
    end else if (frameStb) begin
      seenOneQ <= 1'b0;
    end else if (subHasOne) begin
      seenOneQ <= 1'b1;
    end
  end

  always_comb begin
    strobes = '0;
    strobes.frameTick        = frameStb;
    strobes.setCond[IDX_LOF] = oofIn;
    strobes.clrCond[IDX_LOF] = ~oofIn;
    strobes.setCond[IDX_C1]  = c1In;
    strobes.clrCond[IDX_C1]  = ~c1In;
    strobes.setCond[IDX_RAI] = (xBits == 2'b00);
    strobes.clrCond[IDX_RAI] = (xBits == 2'b11);
    strobes.setCond[IDX_CZ]  = frameZero;
    strobes.clrCond[IDX_CZ]  = 1'b0;
    strobes.instClr[IDX_CZ]  = subAllOne;
    strobes.maskLoad         = maskWr;
    strobes.maskVal          = maskData;
    strobes.ackBits          = clrStb ? clrBits : '0;
  end

endmodule

// File: rtl/ds3d_persist.sv
module ds3d_persist #(
  parameter int SET_N = 8,
  parameter int CLR_N = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic setCond,
  input  logic clrCond,
  input  logic instClr,
  output logic flag,
  output logic change
);

  localparam int CW = $clog2(ds3d_pkg::maxOf(SET_N, CLR_N) + 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SET_N - 1);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLR_N - 1);

  logic          flagQ, flagD;
  logic [CW-1:0] runQ, runD;

  always_comb begin
    flagD = flagQ;
    runD  = runQ;
    if (instClr) begin
      flagD = 1'b0;
      runD  = '0;
    end else if (tick) begin
      if (!flagQ) begin
        if (!setCond) begin
          runD = '0;
        end else if (runQ == SET_LAST) begin
          flagD = 1'b1;
          runD  = '0;
        end else begin
          runD = runQ + 1'b1;
        end
      end else begin
        if (!clrCond) begin
          runD = '0;
        end else if (runQ == CLR_LAST) begin
          flagD = 1'b0;
          runD  = '0;
        end else begin
          runD = runQ + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      runQ  <= '0;
    end else begin
      flagQ <= flagD;
      runQ  <= runD;
    end
  end

  assign flag   = flagQ;
  assign change = flagD ^ flagQ;

endmodule

// File: rtl/ds3d_datapath.sv
module ds3d_datapath
  import ds3d_pkg::*;
#(
  parameter int LOF_SET = 28,
  parameter int LOF_CLR = 28,
  parameter int C1_SET  = 8,
  parameter int C1_CLR  = 3,
  parameter int RAI_SET = 2,
  parameter int RAI_CLR = 2,
  parameter int CZ_SET  = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  output defVec_t      flags,
  output defVec_t      evtPulse,
  output defVec_t      maskReg,
  output logic         irqOut
);

  defVec_t changeVec;
  defVec_t pulseQ;
  defVec_t stickyQ;
  defVec_t maskQ;

  for (genvar i = 0; i < NUM_DEF; i++) begin : g_def
    localparam int SN = (i == IDX_LOF) ? LOF_SET :
                        (i == IDX_C1)  ? C1_SET  :
                        (i == IDX_RAI) ? RAI_SET : CZ_SET;
    localparam int CN = (i == IDX_LOF) ? LOF_CLR :
                        (i == IDX_C1)  ? C1_CLR  :
                        (i == IDX_RAI) ? RAI_CLR : 1;
    ds3d_persist #(.SET_N(SN), .CLR_N(CN)) u_persist (
      .clk     (clk),
      .rstN    (rstN),
      .tick    (strobes.frameTick),
      .setCond (strobes.setCond[i]),
      .clrCond (strobes.clrCond[i]),
      .instClr (strobes.instClr[i]),
      .flag    (flags[i]),
      .change  (changeVec[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseQ  <= '0;
      stickyQ <= '0;
      maskQ   <= '0;
    end else begin
      pulseQ  <= changeVec;
      stickyQ <= (stickyQ & ~strobes.ackBits) | changeVec;
      if (strobes.maskLoad) begin
        maskQ <= strobes.maskVal;
      end
    end
  end

  assign evtPulse = pulseQ;
  assign maskReg  = maskQ;
  assign irqOut   = |(stickyQ & ~maskQ);

endmodule

// File: rtl/ds3_defect_integrator.sv
module ds3_defect_integrator
  import ds3d_pkg::*;
#(
  parameter int LOF_SET = 28,
  parameter int LOF_CLR = 28,
  parameter int C1_SET  = 8,
  parameter int C1_CLR  = 3,
  parameter int RAI_SET = 2,
  parameter int RAI_CLR = 2,
  parameter int CZ_SET  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStb,
  input  logic       oofIn,
  input  logic [1:0] xBits,
  input  logic       c1In,
  input  logic       subStb,
  input  logic [2:0] subCBits,
  input  logic       maskWr,
  input  logic [3:0] maskData,
  input  logic       clrStb,
  input  logic [3:0] clrBits,
  output logic       lofOut,
  output logic       c1HighOut,
  output logic       raiOut,
  output logic       cZeroOut,
  output logic [3:0] evtPulse,
  output logic       irqOut
);

  ctrlStrobes_t strobes;
  defVec_t      flags;
  defVec_t      maskReg;

  ds3d_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameStb (frameStb),
    .oofIn    (oofIn),
    .xBits    (xBits),
    .c1In     (c1In),
    .subStb   (subStb),
    .subCBits (subCBits),
    .maskWr   (maskWr),
    .maskData (maskData),
    .clrStb   (clrStb),
    .clrBits  (clrBits),
    .strobes  (strobes)
  );

  ds3d_datapath #(
    .LOF_SET (LOF_SET), .LOF_CLR (LOF_CLR),
    .C1_SET  (C1_SET),  .C1_CLR  (C1_CLR),
    .RAI_SET (RAI_SET), .RAI_CLR (RAI_CLR),
    .CZ_SET  (CZ_SET)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .flags    (flags),
    .evtPulse (evtPulse),
    .maskReg  (maskReg),
    .irqOut   (irqOut)
  );

  assign lofOut    = flags[IDX_LOF];
  assign c1HighOut = flags[IDX_C1];
  assign raiOut    = flags[IDX_RAI];
  assign cZeroOut  = flags[IDX_CZ];

endmodule

// File: rtl/ds3d_checker.sv
module ds3d_checker (
  input logic       clk,
  input logic       rstN,
  input logic       frameStb,
  input logic       oofIn,
  input logic [1:0] xBits,
  input logic       c1In,
  input logic       subStb,
  input logic [2:0] subCBits,
  input logic       lofOut,
  input logic       c1HighOut,
  input logic       raiOut,
  input logic       cZeroOut,
  input logic [3:0] evtPulse,
  input logic [3:0] maskReg,
  input logic       irqOut
);

  logic [3:0] flagVec;
  assign flagVec = {cZeroOut, raiOut, c1HighOut, lofOut};

  AST_LOF_RISE_ON_OOF_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lofOut) |-> $past(frameStb && oofIn)); // R1
  AST_LOF_FALL_ON_CLEAN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lofOut) |-> $past(frameStb && !oofIn)); // R2
  AST_C1_RISE_ON_HIGH_C1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(c1HighOut) |-> $past(frameStb && c1In)); // R3
  AST_C1_FALL_ON_LOW_C1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(c1HighOut) |-> $past(frameStb && !c1In)); // R4
  AST_RAI_RISE_ON_ZERO_X: assert property (@(posedge clk) disable iff (!rstN)
    $rose(raiOut) |-> $past(frameStb && xBits == 2'b00)); // R5
  AST_RAI_FALL_ON_ONE_X: assert property (@(posedge clk) disable iff (!rstN)
    $fell(raiOut) |-> $past(frameStb && xBits == 2'b11)); // R5
  AST_CZ_RISE_ON_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cZeroOut) |-> $past(frameStb)); // R6
  AST_CZ_FALL_ON_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cZeroOut) |-> $past(subStb && subCBits == 3'b111)); // R7
  AST_CZ_ALL_ONES_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (subStb && subCBits == 3'b111) |=> !cZeroOut); // R7
  AST_PULSE_MATCHES_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse == (flagVec ^ $past(flagVec))); // R9
  AST_IRQ_ON_UNMASKED_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (|(evtPulse & ~maskReg)) |-> irqOut); // R10

endmodule

bind ds3_defect_integrator ds3d_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .frameStb  (frameStb),
  .oofIn     (oofIn),
  .xBits     (xBits),
  .c1In      (c1In),
  .subStb    (subStb),
  .subCBits  (subCBits),
  .lofOut    (lofOut),
  .c1HighOut (c1HighOut),
  .raiOut    (raiOut),
  .cZeroOut  (cZeroOut),
  .evtPulse  (evtPulse),
  .maskReg   (maskReg),
  .irqOut    (irqOut)
);

// File: tb/ds3_defect_integrator_test.sv
`timescale 1ns/1ps
module ds3_defect_integrator_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStb = 1'b0;
  logic       oofIn = 1'b0;
  logic [1:0] xBits = 2'b11;
  logic       c1In = 1'b0;
  logic       subStb = 1'b0;
  logic [2:0] subCBits = 3'b010;
  logic       maskWr = 1'b0;
  logic [3:0] maskData = 4'h0;
  logic       clrStb = 1'b0;
  logic [3:0] clrBits = 4'h0;
  logic       lofOut, c1HighOut, raiOut, cZeroOut, irqOut;
  logic [3:0] evtPulse;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ds3_defect_integrator uut (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .oofIn(oofIn), .xBits(xBits),
    .c1In(c1In), .subStb(subStb), .subCBits(subCBits), .maskWr(maskWr),
    .maskData(maskData), .clrStb(clrStb), .clrBits(clrBits), .lofOut(lofOut),
    .c1HighOut(c1HighOut), .raiOut(raiOut), .cZeroOut(cZeroOut),
    .evtPulse(evtPulse), .irqOut(irqOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    frameStb = 0; subStb = 0; maskWr = 0; clrStb = 0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // two subframes then an end-of-frame strobe; returns at the negedge after the update
  task automatic doFrame(input logic oof, input logic [1:0] x, input logic c1,
                         input logic [2:0] cb);
    for (int s = 0; s < 2; s++) begin
      subStb = 1'b1; subCBits = cb;
      @(negedge clk);
      subStb = 1'b0;
    end
    frameStb = 1'b1; oofIn = oof; xBits = x; c1In = c1;
    @(negedge clk);
    frameStb = 1'b0;
  endtask

  initial begin
    doReset();
    chk("R11 flags", {cZeroOut, raiOut, c1HighOut, lofOut}, 0);
    chk("R11 pulse", evtPulse, 0);
    chk("R11 irq", irqOut, 0);

    // R1 sweep of set run length
    for (int n = 26; n <= 29; n++) begin
      doReset();
      for (int f = 0; f < n; f++) begin
        doFrame(1'b1, 2'b11, 1'b0, 3'b010);
        if (f == 27) chk("R9 lof pulse", evtPulse, 4'b0001);
      end
      chk("R1 lof after run", lofOut, (n >= 28) ? 1 : 0);
    end
    @(negedge clk);
    chk("R9 pulse one cycle", evtPulse, 0);

    // R2 sweep of clear run length
    for (int m = 27; m <= 28; m++) begin
      doReset();
      for (int f = 0; f < 28; f++) doFrame(1'b1, 2'b11, 1'b0, 3'b010);
      for (int f = 0; f < m; f++) doFrame(1'b0, 2'b11, 1'b0, 3'b010);
      chk("R2 lof after clear run", lofOut, (m >= 28) ? 0 : 1);
    end

    // R8 broken run restarts
    doReset();
    for (int f = 0; f < 20; f++) doFrame(1'b1, 2'b11, 1'b0, 3'b010);
    doFrame(1'b0, 2'b11, 1'b0, 3'b010);
    for (int f = 0; f < 27; f++) doFrame(1'b1, 2'b11, 1'b0, 3'b010);
    chk("R8 lof after broken run", lofOut, 0);
    doFrame(1'b1, 2'b11, 1'b0, 3'b010);
    chk("R8 lof after full run", lofOut, 1);

    // R3 sweep
    for (int n = 1; n <= 9; n++) begin
      doReset();
      for (int f = 0; f < n; f++) doFrame(1'b0, 2'b11, 1'b1, 3'b010);
      chk("R3 c1 after run", c1HighOut, (n >= 8) ? 1 : 0);
    end
    // R4 sweep
    for (int m = 1; m <= 4; m++) begin
      doReset();
      for (int f = 0; f < 8; f++) doFrame(1'b0, 2'b11, 1'b1, 3'b010);
      for (int f = 0; f < m; f++) doFrame(1'b0, 2'b11, 1'b0, 3'b010);
      chk("R4 c1 after clear run", c1HighOut, (m >= 3) ? 0 : 1);
    end

    // R5 remote alarm
    doReset();
    doFrame(1'b0, 2'b00, 1'b0, 3'b010);
    chk("R5 rai after one", raiOut, 0);
    doFrame(1'b0, 2'b00, 1'b0, 3'b010);
    chk("R5 rai after two", raiOut, 1);
    doFrame(1'b0, 2'b11, 1'b0, 3'b010);
    doFrame(1'b0, 2'b01, 1'b0, 3'b010);
    doFrame(1'b0, 2'b11, 1'b0, 3'b010);
    chk("R5 rai mixed x breaks clear", raiOut, 1);
    doFrame(1'b0, 2'b11, 1'b0, 3'b010);
    chk("R5 rai cleared", raiOut, 0);
    doFrame(1'b0, 2'b00, 1'b0, 3'b010);
    doFrame(1'b0, 2'b10, 1'b0, 3'b010);
    doFrame(1'b0, 2'b00, 1'b0, 3'b010);
    chk("R5 rai mixed x breaks set", raiOut, 0);
    doFrame(1'b0, 2'b00, 1'b0, 3'b010);
    chk("R5 rai set again", raiOut, 1);

    // R6 / R7 all-C-zero
    doReset();
    doFrame(1'b0, 2'b11, 1'b0, 3'b000);
    doFrame(1'b0, 2'b11, 1'b0, 3'b000);
    chk("R6 cz after two", cZeroOut, 0);
    doFrame(1'b0, 2'b11, 1'b0, 3'b000);
    chk("R6 cz after three", cZeroOut, 1);
    subStb = 1'b1; subCBits = 3'b111;
    @(negedge clk);
    subStb = 1'b0;
    chk("R7 cz dropped mid-frame", cZeroOut, 0);
    chk("R9 cz pulse", evtPulse, 4'b1000);
    frameStb = 1'b1;
    @(negedge clk);
    frameStb = 1'b0;
    doFrame(1'b0, 2'b11, 1'b0, 3'b000);
    doFrame(1'b0, 2'b11, 1'b0, 3'b001);
    doFrame(1'b0, 2'b11, 1'b0, 3'b000);
    doFrame(1'b0, 2'b11, 1'b0, 3'b000);
    chk("R8 cz run broken by a one", cZeroOut, 0);
    doFrame(1'b0, 2'b11, 1'b0, 3'b000);
    chk("R6 cz after restart", cZeroOut, 1);

    // R10 interrupt path
    doReset();
    maskWr = 1'b1; maskData = 4'b0100;
    @(negedge clk);
    maskWr = 1'b0;
    doFrame(1'b0, 2'b00, 1'b0, 3'b010);
    doFrame(1'b0, 2'b00, 1'b0, 3'b010);
    chk("R10 masked event no irq", irqOut, 0);
    maskWr = 1'b1; maskData = 4'b0000;
    @(negedge clk);
    maskWr = 1'b0;
    chk("R10 unmask raises irq", irqOut, 1);
    clrStb = 1'b1; clrBits = 4'b0001;
    @(negedge clk);
    clrStb = 1'b0;
    chk("R10 other-bit clear keeps irq", irqOut, 1);
    clrStb = 1'b1; clrBits = 4'b0100;
    @(negedge clk);
    clrStb = 1'b0;
    chk("R10 w1c clears irq", irqOut, 0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule